// File: doc/BRIEF.md
# Switch-on-Miss Thread Controller

This block schedules a small set of hardware thread contexts onto one short in-order pipeline using coarse-grain multithreading. The thread that owns the pipeline keeps issuing until it reports a cache miss. The block then raises a one-cycle flush request so the pipeline drops that thread's younger instructions. It records the thread as waiting on memory and hands the pipeline to another thread that is ready. After a switch, a fixed flush penalty keeps issue disabled for a set number of cycles.

A waiting thread becomes eligible again when its memory return pulse arrives. It never takes the pipeline away from a running thread. If every context is waiting, the block reports that the core is idle. It then resumes the first thread whose return arrives. Miss pulses that do not come from the thread that is currently issuing are treated as stale and dropped. The caches and the memory system stay outside the block.

Top module: `miss_switch_ctrl`

## Requirements
- R1: After reset, `active_tid` is 0, `issue_en` is 1, `flush_req` is 0, `all_idle` is 0, and no thread is waiting.
- R2: `active_tid` changes only when a miss is accepted or when the block resumes from idle.
- R3: A miss is accepted when `miss_valid` is high, `miss_tid` equals `active_tid` and `issue_en` is 1. In the next cycle `flush_req` is high for exactly one cycle, and the missing thread is marked waiting.
- R4: After an accepted miss, `issue_en` stays 0 for exactly FLUSH_CYCLES cycles (default 4) and then returns to 1, unless the block is idle.
- R5: The thread that takes over is found by searching upward from `active_tid`+1, wrapping at NUM_THREADS, and is the first thread that is not waiting.
- R6: A pulse on `fill_done[k]` clears the waiting mark of thread k. It does not preempt the running thread.
- R7: A return and an accepted miss can fall in the same cycle. In that case the returning thread is already eligible for the switch. If the return belongs to the missing thread itself, the miss still marks that thread waiting.
- R8: When an accepted miss leaves no thread ready, `all_idle` goes to 1, `active_tid` keeps its value and `issue_en` stays 0.
- R9: While idle, the first cycle with a return makes the returning thread active and clears `all_idle`. If several threads return in that cycle, the round-robin order of R5 decides between them. `issue_en` returns to 1 once the flush penalty has drained.
- R10: A miss pulse is ignored in three cases: its ID differs from `active_tid`, `issue_en` is 0 (during the penalty), or the block is idle. An ignored miss produces no flush and no change of `active_tid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Cache miss pulse |
| miss_tid | input | TID_W | Thread ID tagging the miss |
| fill_done | input | NUM_THREADS | Per-thread memory return pulses |
| flush_req | output | 1 | One-cycle request to flush younger instructions |
| issue_en | output | 1 | The active thread may issue this cycle |
| active_tid | output | TID_W | Thread currently owning fetch |
| all_idle | output | 1 | Every thread is waiting on memory |

## Verification
The two functions that can coincide are the acceptance of a miss from the running thread and a memory return for some thread. The bench drives both in one cycle in two setups. In the first, the returning thread is the only one not waiting, so the switch must land on it. In the second, the return belongs to the missing thread itself, so that thread must still end up waiting and be skipped. The result is judged from `active_tid`, `flush_req` and `issue_en` after the edge, against values the scoreboard predicts from the waiting set the bench tracks.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

   // Scheduling mode of the core as seen by the controller
   typedef enum logic {
      CORE_RUN    = 1'b0,
      CORE_PARKED = 1'b1
   } core_mode_e;

   function automatic int tid_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/mtc_wait_set.sv
module mtc_wait_set #(
   parameter int NUM_THREADS = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_THREADS-1:0] set_vec,
   input  logic [NUM_THREADS-1:0] clr_vec,
   output logic [NUM_THREADS-1:0] wait_d,
   output logic [NUM_THREADS-1:0] wait_q
);

   // a new miss outranks a return landing in the same cycle
   assign wait_d = (wait_q & ~clr_vec) | set_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) wait_q <= '0;
      else        wait_q <= wait_d;
   end

   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((wait_q & $past(set_vec)) == $past(set_vec)));

   // R6
   clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_vec & ~set_vec) != '0) |=> ((wait_q & $past(clr_vec & ~set_vec)) == '0));

endmodule

// File: rtl/mtc_rr_pick.sv
module mtc_rr_pick #(
   parameter int NUM_THREADS = 4,
   parameter int TID_W       = 2
) (
   input  logic [NUM_THREADS-1:0] req_vec,
   input  logic [TID_W-1:0]       base_tid,
   output logic                   found,
   output logic [TID_W-1:0]       pick_tid
);

   generate
      if (NUM_THREADS == 1) begin : g_single
         assign found    = req_vec[0];
         assign pick_tid = '0;
      end else begin : g_multi
         always_comb begin
            found    = 1'b0;
            pick_tid = '0;
            for (int k = 1; k <= NUM_THREADS; k++) begin
               int idx;
               idx = (int'(base_tid) + k) % NUM_THREADS;
               if (!found && req_vec[idx]) begin
                  found    = 1'b1;
                  pick_tid = TID_W'(idx);
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/mtc_flush_timer.sv
module mtc_flush_timer #(
   parameter int CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic busy
);

   generate
      if (CYCLES == 0) begin : g_none
         assign busy = 1'b0;
      end else begin : g_count
         localparam int CW = $clog2(CYCLES + 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n)           cnt_q <= '0;
            else if (load)        cnt_q <= CW'(CYCLES);
            else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
         end

         assign busy = (cnt_q != '0);

         // R4
         load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            load |=> busy);
      end
   endgenerate

endmodule

// File: rtl/miss_switch_ctrl.sv
module miss_switch_ctrl #(
   parameter int NUM_THREADS  = 4,
   parameter int FLUSH_CYCLES = 4,
   parameter int TID_W        = mtc_pkg::tid_width(NUM_THREADS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   miss_valid,
   input  logic [TID_W-1:0]       miss_tid,
   input  logic [NUM_THREADS-1:0] fill_done,
   output logic                   flush_req,
   output logic                   issue_en,
   output logic [TID_W-1:0]       active_tid,
   output logic                   all_idle
);
   import mtc_pkg::*;

   generate
      if (NUM_THREADS < 1 || NUM_THREADS > 16) begin : g_bad_n
         $error("miss_switch_ctrl: NUM_THREADS out of range");
      end
      if (FLUSH_CYCLES < 0) begin : g_bad_f
         $error("miss_switch_ctrl: FLUSH_CYCLES negative");
      end
      if (TID_W < mtc_pkg::tid_width(NUM_THREADS)) begin : g_bad_w
         $error("miss_switch_ctrl: TID_W too narrow");
      end
   endgenerate

   core_mode_e             mode_q;
   logic [TID_W-1:0]       act_q;
   logic                   flush_q;
   logic                   pen_busy;
   logic                   take_miss;
   logic [NUM_THREADS-1:0] set_vec;
   logic [NUM_THREADS-1:0] wait_d, wait_q;
   logic                   sw_found, wk_found;
   logic [TID_W-1:0]       sw_tid, wk_tid;

   assign issue_en  = (mode_q == CORE_RUN) && !pen_busy;
   assign take_miss = miss_valid && (miss_tid == act_q) && issue_en;

   always_comb begin
      set_vec = '0;
      if (take_miss) set_vec[act_q] = 1'b1;
   end

   mtc_wait_set #(.NUM_THREADS(NUM_THREADS)) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (fill_done),
      .wait_d  (wait_d),
      .wait_q  (wait_q)
   );

   // successor for a switch: threads not waiting after this cycle's updates
   mtc_rr_pick #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_sw_pick (
      .req_vec  (~wait_d),
      .base_tid (act_q),
      .found    (sw_found),
      .pick_tid (sw_tid)
   );

   // wake-up while parked: threads whose data has just returned
   mtc_rr_pick #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_wk_pick (
      .req_vec  (fill_done & wait_q),
      .base_tid (act_q),
      .found    (wk_found),
      .pick_tid (wk_tid)
   );

   mtc_flush_timer #(.CYCLES(FLUSH_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (take_miss),
      .busy  (pen_busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= CORE_RUN;
         act_q   <= '0;
         flush_q <= 1'b0;
      end else begin
         flush_q <= take_miss;
         if (take_miss) begin
            if (sw_found) act_q  <= sw_tid;
            else          mode_q <= CORE_PARKED;
         end else if (mode_q == CORE_PARKED && wk_found) begin
            act_q  <= wk_tid;
            mode_q <= CORE_RUN;
         end
      end
   end

   assign flush_req  = flush_q;
   assign active_tid = act_q;
   assign all_idle   = (mode_q == CORE_PARKED);

   // R3
   flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |=> !flush_req);

   // R3
   miss_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && miss_tid == active_tid && issue_en) |=> flush_req);

   // R10
   stale_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && (miss_tid != active_tid || !issue_en)) |=> !flush_req);

   // R8
   idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      all_idle |-> !issue_en);

   // R2
   hold_tid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!all_idle && !(miss_valid && miss_tid == active_tid && issue_en))
         |=> $stable(active_tid));

   // R5
   pick_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_miss && sw_found) |=> !wait_q[active_tid]);

   // R4
   penalty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |-> (FLUSH_CYCLES == 0 || !issue_en));

endmodule

// File: tb/sim_miss_switch_ctrl.sv
module sim_miss_switch_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NT = 4;
   localparam int TW = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          miss_valid = 1'b0;
   logic [TW-1:0] miss_tid = '0;
   logic [NT-1:0] fill_done = '0;
   logic          flush_req, issue_en, all_idle;
   logic [TW-1:0] active_tid;

   typedef struct {
      int tid;
      bit flush;
      bit iss;
      bit idle;
      int rid;
   } exp_t;

   exp_t exp_q[$];
   int   n_vec = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   miss_switch_ctrl #(.NUM_THREADS(NT), .FLUSH_CYCLES(4)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .miss_valid (miss_valid),
      .miss_tid   (miss_tid),
      .fill_done  (fill_done),
      .flush_req  (flush_req),
      .issue_en   (issue_en),
      .active_tid (active_tid),
      .all_idle   (all_idle)
   );

   // driver: one cycle of stimulus plus the outcome expected after the edge
   task automatic step(input bit mv, input int mt, input logic [NT-1:0] ret,
                       input int ea, input bit ef, input bit ei, input bit eid,
                       input int rid);
      exp_t e;
      @(negedge clk);
      miss_valid = mv;
      miss_tid   = TW'(mt);
      fill_done  = ret;
      e.tid = ea; e.flush = ef; e.iss = ei; e.idle = eid; e.rid = rid;
      exp_q.push_back(e);
   endtask

   // monitor: compare a quarter period after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_PERIOD/4);
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_vec++;
            if (int'(active_tid) != e.tid || flush_req != e.flush ||
                issue_en != e.iss || all_idle != e.idle) begin
               n_bad++;
               $display("FAIL R%0d: tid/flush/iss/idle got %0d/%0b/%0b/%0b exp %0d/%0b/%0b/%0b",
                        e.rid, active_tid, flush_req, issue_en, all_idle,
                        e.tid, e.flush, e.iss, e.idle);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog: got running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #(CLK_PERIOD/4);
      // R1 reset state
      n_vec++;
      if (active_tid != 0 || flush_req || !issue_en || all_idle) begin
         n_bad++;
         $display("FAIL R1: tid/flush/iss/idle got %0d/%0b/%0b/%0b exp 0/0/1/0",
                  active_tid, flush_req, issue_en, all_idle);
      end
      @(negedge clk);
      rst_n = 1'b1;

      step(0, 0, 4'b0000, 0, 0, 1, 0, 1);  // R1 no waiting thread, runs
      step(1, 0, 4'b0000, 1, 1, 0, 0, 3);  // R3 miss on 0 -> 1
      step(1, 2, 4'b0000, 1, 0, 0, 0, 10); // R10 stale tid during penalty
      step(0, 0, 4'b0000, 1, 0, 0, 0, 4);  // R4
      step(0, 0, 4'b0000, 1, 0, 0, 0, 4);  // R4
      step(0, 0, 4'b0000, 1, 0, 1, 0, 4);  // R4 penalty ends
      step(1, 3, 4'b0000, 1, 0, 1, 0, 10); // R10 wrong tid ignored
      step(1, 1, 4'b0000, 2, 1, 0, 0, 5);  // R5 skip waiting 0 -> 2
      step(0, 0, 4'b0000, 2, 0, 0, 0, 4);  // R4
      step(0, 0, 4'b0000, 2, 0, 0, 0, 4);  // R4
      step(0, 0, 4'b0000, 2, 0, 0, 0, 4);  // R4
      step(0, 0, 4'b0000, 2, 0, 1, 0, 2);  // R2 holds
      step(1, 2, 4'b0000, 3, 1, 0, 0, 5);  // R5 -> 3
      step(0, 0, 4'b0000, 3, 0, 0, 0, 4);  // R4
      step(0, 0, 4'b0000, 3, 0, 0, 0, 4);  // R4
      step(0, 0, 4'b0000, 3, 0, 0, 0, 4);  // R4
      step(0, 0, 4'b0000, 3, 0, 1, 0, 4);  // R4
      step(1, 3, 4'b0010, 1, 1, 0, 0, 7);  // R7 return of 1 same cycle -> 1
      step(0, 0, 4'b0000, 1, 0, 0, 0, 4);  // R4
      step(0, 0, 4'b0000, 1, 0, 0, 0, 4);  // R4
      step(0, 0, 4'b0000, 1, 0, 0, 0, 4);  // R4
      step(0, 0, 4'b0000, 1, 0, 1, 0, 4);  // R4
      step(1, 1, 4'b0000, 1, 1, 0, 1, 8);  // R8 all waiting -> idle
      step(1, 1, 4'b0000, 1, 0, 0, 1, 10); // R10 miss while idle ignored
      step(0, 0, 4'b0000, 1, 0, 0, 1, 8);  // R8
      step(0, 0, 4'b0000, 1, 0, 0, 1, 8);  // R8
      step(0, 0, 4'b0000, 1, 0, 0, 1, 8);  // R8 penalty drained, still idle
      step(0, 0, 4'b0100, 2, 0, 1, 0, 9);  // R9 return of 2 resumes it
      step(0, 0, 4'b1000, 2, 0, 1, 0, 6);  // R6 return of 3, no preempt
      step(1, 2, 4'b0100, 3, 1, 0, 0, 7);  // R7 own return loses -> 3
      step(0, 0, 4'b0001, 3, 0, 0, 0, 6);  // R6 return of 0
      step(0, 0, 4'b0000, 3, 0, 0, 0, 4);  // R4
      step(0, 0, 4'b0000, 3, 0, 0, 0, 4);  // R4
      step(0, 0, 4'b0000, 3, 0, 1, 0, 4);  // R4
      step(1, 3, 4'b0000, 0, 1, 0, 0, 5);  // R5 wrap 3 -> 0
      step(0, 0, 4'b0000, 0, 0, 0, 0, 2);  // R2

      @(negedge clk);
      miss_valid = 1'b0;
      fill_done  = '0;
      repeat (3) @(posedge clk);
      #(CLK_PERIOD/2);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule